// File: doc/BRIEF.md
# Rotating Packet Buffer with Automatic Commit

This block sits between a sampling front end and a bulk-IN transmit engine. Sample words arrive on a simple valid strobe and are packed into one of several equally sized packet buffers. When the buffer being filled reaches its set size, it is handed to the transmit side at once, with no processor action. The next free buffer then takes the following samples. Buffers are filled and emptied in strict rotation.

The transmit side sees only committed packets. It receives them as a byte stream with valid/ready handshaking and an end-of-packet marker, plus a flag that says at least one packet is waiting. A buffer goes back to the free pool only when its final byte has been accepted. Samples that arrive while every buffer is committed or draining are lost, and a sticky flag records the loss. A synchronous flush throws away all stored data and restarts both rotations at the first buffer.

The defaults give four buffers of 1024 bytes, each taking 512 sixteen-bit samples.

Top module: `pkt_ring_buf`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `overflow`, `pkt_avail` and `out_valid` are 0.
- R2: Each accepted 16-bit word becomes two consecutive output bytes, bits [7:0] first and bits [15:8] second, so one 1024-byte packet carries 512 words.
- R3: A buffer is committed automatically on the clock edge that writes its 512th word. `pkt_avail` is 0 after 511 words and 1 right after that edge.
- R4: Packets leave in the order they were filled, and every byte equals the byte that was written, whatever the pattern of `out_ready`.
- R5: `out_last` is 1 on the 1024th byte of each packet and 0 on every other byte handed over.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.
- R7: `full` is 1 exactly when all four buffers are committed or still draining. A draining buffer is freed only after its 1024th byte is accepted, so `full` stays 1 after 1023 bytes and drops after the 1024th.
- R8: A word presented while `full` is 1 is dropped and sets `overflow`. `overflow` stays 1 until an `ovf_clr` pulse and is not cleared by draining.
- R9: A `flush` pulse discards committed and partial data. On the next cycle `empty` is 1 and `pkt_avail` and `full` are 0, and the next packet written is read back alone and intact.
- R10: `empty` is 1 only when no buffer is committed and the fill buffer holds no words. A single partial word clears `empty` without raising `pkt_avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all contents and pointers |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| in_valid | input | 1 | Sample word strobe |
| in_data | input | 16 | Sample word |
| out_valid | output | 1 | A byte of a committed packet is presented |
| out_data | output | 8 | Presented byte |
| out_ready | input | 1 | Consumer accepts the presented byte |
| out_last | output | 1 | Presented byte is the last of its packet |
| pkt_avail | output | 1 | At least one committed packet is waiting |
| full | output | 1 | Every buffer is committed or draining |
| empty | output | 1 | No committed packet and no partial words |
| overflow | output | 1 | Sticky flag for dropped words |

## Verification
Every status output is registered off the same edge that accepts a word, a byte or a flush. Commit, release, full, empty and overflow are therefore due one edge after the stimulus. The bench drives one time unit after the rising edge and samples status right after the edge that consumed the stimulus. Each byte handshake is scored on the falling edge before the rising edge that completes it, against a queue the write task filled in low-byte-first order. Hold behaviour under backpressure is compared between consecutive falling edges.

// File: rtl/pkb_pkg.sv
package pkb_pkg;
   typedef enum logic {
      LSB_FIRST = 1'b0,
      MSB_FIRST = 1'b1
   } byte_order_e;
endpackage

// File: rtl/pkb_fill_ctrl.sv
module pkb_fill_ctrl #(
   parameter int NUM_BUFS      = 4,
   parameter int WORDS_PER_PKT = 512,
   localparam int BUF_W  = $clog2(NUM_BUFS),
   localparam int IDX_W  = $clog2(WORDS_PER_PKT),
   localparam int ADDR_W = BUF_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic              space_ok,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              commit,
   output logic              partial
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS_PER_PKT - 1);
   localparam logic [BUF_W-1:0] BUF_ONE  = BUF_W'(1);
   localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

   logic [BUF_W-1:0] fill_buf;
   logic [IDX_W-1:0] fill_idx;

   assign wr_en   = in_valid & space_ok & ~flush;
   assign commit  = wr_en & (fill_idx == LAST_IDX);
   assign wr_addr = {fill_buf, fill_idx};
   assign partial = (fill_idx != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_buf <= '0;
         fill_idx <= '0;
      end else if (flush) begin
         fill_buf <= '0;
         fill_idx <= '0;
      end else if (commit) begin
         fill_buf <= fill_buf + BUF_ONE;
         fill_idx <= '0;
      end else if (wr_en) begin
         fill_idx <= fill_idx + IDX_ONE;
      end
   end
endmodule

// File: rtl/pkb_drain_ctrl.sv
module pkb_drain_ctrl #(
   parameter int NUM_BUFS      = 4,
   parameter int BYTES_PER_PKT = 1024,
   parameter int BYTES_PER_WD  = 2,
   localparam int BUF_W  = $clog2(NUM_BUFS),
   localparam int BYTE_W = $clog2(BYTES_PER_PKT),
   localparam int LANE_W = $clog2(BYTES_PER_WD),
   localparam int ADDR_W = BUF_W + BYTE_W - LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              avail,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LANE_W-1:0] rd_lane,
   output logic              out_valid,
   output logic              out_last,
   output logic              release_buf
);
   localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BYTES_PER_PKT - 1);
   localparam logic [BUF_W-1:0]  BUF_ONE   = BUF_W'(1);
   localparam logic [BYTE_W-1:0] BYTE_ONE  = BYTE_W'(1);

   logic [BUF_W-1:0]  drain_buf;
   logic [BYTE_W-1:0] drain_byte;
   logic              take;

   assign out_valid   = avail;
   assign out_last    = avail & (drain_byte == LAST_BYTE);
   assign take        = out_valid & out_ready;
   assign release_buf = take & out_last;
   assign rd_addr     = {drain_buf, drain_byte[BYTE_W-1:LANE_W]};
   assign rd_lane     = drain_byte[LANE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drain_buf  <= '0;
         drain_byte <= '0;
      end else if (flush) begin
         drain_buf  <= '0;
         drain_byte <= '0;
      end else if (release_buf) begin
         drain_buf  <= drain_buf + BUF_ONE;
         drain_byte <= '0;
      end else if (take) begin
         drain_byte <= drain_byte + BYTE_ONE;
      end
   end
endmodule

// File: rtl/pkb_store.sv
module pkb_store
   import pkb_pkg::*;
#(
   parameter int          WORD_W     = 16,
   parameter int          DEPTH      = 2048,
   parameter byte_order_e BYTE_ORDER = LSB_FIRST,
   localparam int BYTES_PER_WD = WORD_W / 8,
   localparam int LANE_W       = $clog2(BYTES_PER_WD),
   localparam int ADDR_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [LANE_W-1:0] lane,
   output logic [7:0]        rbyte
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] rword;
   logic [LANE_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rword = mem[raddr];

   generate
      if (BYTE_ORDER == LSB_FIRST) begin : g_lsb
         assign sel = lane;
      end else begin : g_msb
         assign sel = LANE_W'(BYTES_PER_WD - 1) - lane;
      end
   endgenerate

   assign rbyte = rword[sel*8 +: 8];
endmodule

// File: rtl/pkt_ring_buf.sv
module pkt_ring_buf
   import pkb_pkg::*;
#(
   parameter int          WORD_W        = 16,
   parameter int          BYTES_PER_PKT = 1024,
   parameter int          NUM_BUFS      = 4,
   parameter byte_order_e BYTE_ORDER    = LSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ovf_clr,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   output logic [7:0]        out_data,
   input  logic              out_ready,
   output logic              out_last,
   output logic              pkt_avail,
   output logic              full,
   output logic              empty,
   output logic              overflow
);
   localparam int BYTES_PER_WD  = WORD_W / 8;
   localparam int WORDS_PER_PKT = BYTES_PER_PKT / BYTES_PER_WD;
   localparam int DEPTH         = NUM_BUFS * WORDS_PER_PKT;
   localparam int ADDR_W        = $clog2(DEPTH);
   localparam int LANE_W        = $clog2(BYTES_PER_WD);
   localparam int CNT_W         = $clog2(NUM_BUFS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_BUFS);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   if (WORD_W % 8 != 0 || BYTES_PER_WD < 2) begin : g_bad_word
      $error("WORD_W must be a multiple of 8 and at least 16");
   end
   if ((BYTES_PER_WD & (BYTES_PER_WD - 1)) != 0) begin : g_bad_lanes
      $error("bytes per word must be a power of two");
   end
   if (NUM_BUFS < 2 || (NUM_BUFS & (NUM_BUFS - 1)) != 0) begin : g_bad_bufs
      $error("NUM_BUFS must be a power of two, at least 2");
   end
   if (BYTES_PER_PKT % BYTES_PER_WD != 0 ||
       (BYTES_PER_PKT & (BYTES_PER_PKT - 1)) != 0 ||
       BYTES_PER_PKT < 2 * BYTES_PER_WD) begin : g_bad_pkt
      $error("BYTES_PER_PKT must be a power of two holding two or more words");
   end

   logic [CNT_W-1:0]  used;
   logic              wr_en;
   logic              commit;
   logic              release_buf;
   logic              partial;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [LANE_W-1:0] rd_lane;

   assign full      = (used == CNT_FULL);
   assign pkt_avail = (used != '0);
   assign empty     = (used == '0) & ~partial;

   pkb_fill_ctrl #(
      .NUM_BUFS      (NUM_BUFS),
      .WORDS_PER_PKT (WORDS_PER_PKT)
   ) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .in_valid (in_valid),
      .space_ok (~full),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .commit   (commit),
      .partial  (partial)
   );

   pkb_drain_ctrl #(
      .NUM_BUFS      (NUM_BUFS),
      .BYTES_PER_PKT (BYTES_PER_PKT),
      .BYTES_PER_WD  (BYTES_PER_WD)
   ) u_drain (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .avail       (pkt_avail),
      .out_ready   (out_ready),
      .rd_addr     (rd_addr),
      .rd_lane     (rd_lane),
      .out_valid   (out_valid),
      .out_last    (out_last),
      .release_buf (release_buf)
   );

   pkb_store #(
      .WORD_W     (WORD_W),
      .DEPTH      (DEPTH),
      .BYTE_ORDER (BYTE_ORDER)
   ) u_store (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (in_data),
      .raddr (rd_addr),
      .lane  (rd_lane),
      .rbyte (out_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used <= '0;
      end else if (flush) begin
         used <= '0;
      end else begin
         case ({commit, release_buf})
            2'b10:   used <= used + CNT_ONE;
            2'b01:   used <= used - CNT_ONE;
            default: used <= used;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overflow <= 1'b0;
      end else if (in_valid & full & ~flush) begin
         overflow <= 1'b1;
      end else if (ovf_clr) begin
         overflow <= 1'b0;
      end
   end
endmodule

// File: rtl/pkb_checker.sv
module pkb_checker #(
   parameter int BYTES_PER_PKT = 1024
) (
   input logic       clk,
   input logic       rst_n,
   input logic       flush,
   input logic       ovf_clr,
   input logic       in_valid,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic       out_ready,
   input logic       out_last,
   input logic       pkt_avail,
   input logic       full,
   input logic       empty,
   input logic       overflow
);
   localparam int CW = $clog2(BYTES_PER_PKT);
   localparam logic [CW-1:0] LAST_CNT = CW'(BYTES_PER_PKT - 1);

   logic [CW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   seen <= '0;
      else if (flush)               seen <= '0;
      else if (out_valid & out_ready) begin
         if (out_last) seen <= '0;
         else          seen <= seen + CW'(1);
      end
   end

   // R5
   last_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |-> (out_last == (seen == LAST_CNT)));

   // R6
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

   // R7
   full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (pkt_avail && !empty));

   // R8
   drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && full && !flush) |=> overflow);

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clr) |=> overflow);

   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !pkt_avail && !full));

   // R10
   valid_needs_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pkt_avail && !empty));
endmodule

bind pkt_ring_buf pkb_checker #(.BYTES_PER_PKT(BYTES_PER_PKT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .ovf_clr   (ovf_clr),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_ready (out_ready),
   .out_last  (out_last),
   .pkt_avail (pkt_avail),
   .full      (full),
   .empty     (empty),
   .overflow  (overflow)
);

// File: tb/pkt_ring_buf_tb.sv
module pkt_ring_buf_tb;
   localparam int PKT = 1024;
   localparam int WPP = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        ovf_clr = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready = 1'b0;
   logic        out_last;
   logic        pkt_avail;
   logic        full;
   logic        empty;
   logic        overflow;

   int checks = 0;
   int errors = 0;
   logic [7:0] expq[$];
   int  byte_pos = 0;
   bit  hold_prev = 0;
   logic [7:0] hold_data;
   logic [15:0] seed = 16'h1357;

   always #2 clk = ~clk;

   pkt_ring_buf u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .ovf_clr(ovf_clr),
      .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .out_last(out_last), .pkt_avail(pkt_avail), .full(full),
      .empty(empty), .overflow(overflow)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: one word per cycle, starts and ends one unit after a rising edge
   task automatic put_word(input bit accept);
      seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      in_data  = seed;
      in_valid = 1'b1;
      if (accept) begin
         expq.push_back(seed[7:0]);
         expq.push_back(seed[15:8]);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic put_words(input int n);
      for (int i = 0; i < n; i++) put_word(1'b1);
   endtask

   task automatic drain(input int n);
      out_ready = 1'b1;
      repeat (n) @(posedge clk);
      #1 out_ready = 1'b0;
   endtask

   task automatic pulse_flush();
      flush = 1'b1;
      @(posedge clk); #1;
      flush = 1'b0;
   endtask

   // monitor: scores each handshake before the edge that completes it
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_prev && !flush) begin
            chk("R6", "valid held", int'(out_valid), 1);
            chk("R6", "data held", int'(out_data), int'(hold_data));
         end
         hold_prev = out_valid && !out_ready && !flush;
         hold_data = out_data;
         if (out_valid && out_ready && !flush) begin
            if (expq.size() == 0) begin
               chk("R4", "unexpected byte", 1, 0);
            end else begin
               chk("R2", "byte value", int'(out_data), int'(expq.pop_front()));
            end
            chk("R5", "last flag", int'(out_last), int'(byte_pos == PKT - 1));
            byte_pos = (byte_pos == PKT - 1) ? 0 : byte_pos + 1;
         end
      end
   end

   task automatic run_all();
      #1;
      // R1 / R10: reset state
      chk("R1", "empty", int'(empty), 1);
      chk("R1", "full", int'(full), 0);
      chk("R1", "overflow", int'(overflow), 0);
      chk("R1", "pkt_avail", int'(pkt_avail), 0);
      chk("R1", "out_valid", int'(out_valid), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R10: partial word clears empty only
      put_words(1);
      chk("R10", "empty after one word", int'(empty), 0);
      chk("R10", "pkt_avail after one word", int'(pkt_avail), 0);
      // R3: commit exactly on the 512th word
      put_words(WPP - 2);
      chk("R3", "pkt_avail after 511", int'(pkt_avail), 0);
      put_words(1);
      chk("R3", "pkt_avail after 512", int'(pkt_avail), 1);
      // R7: not freed before its last byte
      drain(PKT - 1);
      chk("R7", "still held after 1023", int'(pkt_avail), 1);
      drain(1);
      chk("R7", "freed after 1024", int'(pkt_avail), 0);
      chk("R10", "empty after drain", int'(empty), 1);

      // R7 / R8: fill all buffers then overrun
      put_words(3 * WPP);
      chk("R7", "full with three", int'(full), 0);
      put_words(WPP);
      chk("R7", "full with four", int'(full), 1);
      put_word(1'b0);
      put_word(1'b0);
      chk("R8", "overflow set", int'(overflow), 1);
      repeat (5) @(posedge clk); #1;
      chk("R8", "overflow sticky", int'(overflow), 1);
      drain(PKT - 1);
      chk("R7", "full after 1023", int'(full), 1);
      drain(1);
      chk("R7", "full after 1024", int'(full), 0);
      chk("R8", "overflow survives drain", int'(overflow), 1);
      ovf_clr = 1'b1; @(posedge clk); #1 ovf_clr = 1'b0;
      chk("R8", "overflow cleared", int'(overflow), 0);
      drain(3 * PKT);
      chk("R4", "queue drained", expq.size(), 0);
      chk("R10", "empty after all", int'(empty), 1);

      // R4 / R6: concurrent writing with irregular backpressure
      fork
         put_words(2 * WPP);
         begin
            for (int c = 0; c < 7000; c++) begin
               out_ready = (c % 3 != 0) && (c % 7 != 2);
               @(posedge clk); #1;
            end
            out_ready = 1'b0;
         end
      join
      drain(4);
      chk("R4", "queue after backpressure", expq.size(), 0);
      chk("R4", "pkt_avail after backpressure", int'(pkt_avail), 0);

      // R9: flush discards committed and partial data
      put_words(WPP + 100);
      chk("R9", "pkt_avail before flush", int'(pkt_avail), 1);
      pulse_flush();
      expq.delete();
      byte_pos = 0;
      chk("R9", "empty after flush", int'(empty), 1);
      chk("R9", "pkt_avail after flush", int'(pkt_avail), 0);
      chk("R9", "full after flush", int'(full), 0);
      put_words(WPP);
      chk("R9", "new packet committed", int'(pkt_avail), 1);
      drain(PKT);
      chk("R9", "fresh packet read back", expq.size(), 0);
      chk("R9", "nothing left", int'(pkt_avail), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            chk("R1", "watchdog expired", 1, 0);
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule